// File: doc/BRIEF.md
# Escalating Watchdog Countdown Core

This block is the timing heart of a watchdog. It runs entirely in its own timer clock domain. A down counter is advanced by a programmable prescaler. When the counter runs out for the first time, the block raises an interrupt flag and starts a fresh timeout period. If software has still not acknowledged that interrupt when the counter runs out again, the block escalates and raises a system reset request. The reset request stays set until the core itself is reset.

All control inputs are assumed to be already synchronised into the timer clock. They are:
- the timeout value and the prescale value;
- a master enable;
- separate enables for the interrupt and reset outputs;
- an interrupt acknowledge;
- a suspend control that pauses counting for debug or sleep.

Register access, write protection and clock-domain crossing are handled by the surrounding logic. The current count is exported so that it can be read back.

Top module: `wdog_core`

## Requirements
- R1: After `rst_n` is deasserted, `count` is 0 and both `irq` and `sys_rst` are 0.
- R2: A load happens in any cycle where `cfg_enable` is 1 but was 0 at the previous clock edge, or where `cfg_timeout` differs from its value at the previous edge. On a load, the next clock edge sets `count` to the effective timeout (`cfg_timeout`, with 0 read as 1) and restarts the prescaler phase at zero. A load takes priority over counting.
- R3: While the core is running (`cfg_enable`=1 and `suspend`=0) with prescale value P, a counter tick occurs on one clock edge out of every P+1. The first tick comes P+1 edges after a load. With P=0, every running edge is a tick.
- R4: A tick while `count` is 1 is an expiry. An expiry sets the interrupt flag and reloads `count` with the effective timeout; any other tick decrements `count` by one. While running, `count` never shows 0.
- R5: An expiry while the interrupt flag is already set, with `irq_clear` low in that cycle, sets the reset flag.
- R6: `irq_clear`=1 clears the interrupt flag at the next edge and leaves `count` unchanged. If an expiry happens in the same cycle as `irq_clear`, the interrupt flag is set again and no escalation occurs.
- R7: While `suspend`=1, both `count` and the prescaler phase are held. When `suspend` returns to 0, counting resumes from exactly the held values.
- R8: While `cfg_enable`=0, `count` is held. Raising `cfg_enable` again reloads the counter, as described in R2.
- R9: `irq` equals the interrupt flag ANDed with `cfg_irq_en`. `sys_rst` equals the reset flag ANDed with `cfg_rst_en`. Both flags change as described in R4 to R6 regardless of these output enables.
- R10: Once set, the reset flag clears only through `rst_n`. `irq_clear`, disabling and reloading do not clear it.
- R11: With `cfg_timeout`=0, every tick is an expiry, and `count` stays at 1 while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| cfg_timeout | input | CNT_W | Timeout reload value (0 is treated as 1) |
| cfg_prescale | input | PRE_W | Prescale value P; a tick occurs every P+1 clocks |
| cfg_enable | input | 1 | Master enable for counting |
| cfg_irq_en | input | 1 | Gates the interrupt flag onto `irq` |
| cfg_rst_en | input | 1 | Gates the reset flag onto `sys_rst` |
| irq_clear | input | 1 | Acknowledges the interrupt and clears its flag |
| suspend | input | 1 | Freezes the counter and the prescaler phase |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | Sticky system reset request |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the core with an 8-bit counter and a 4-bit prescaler. At this size, the largest timeout (255) and the largest prescale value (15) can both be reached in a few thousand clocks, so the full reload and prescale range is exercised rather than a thin slice of it. The small widths also let two consecutive expiries, and therefore escalation, happen within short windows. This makes it practical to sweep a clear through every cycle offset around an expiry, including the cycle where the clear and the expiry coincide.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Events passed between the prescaler, the counter and the escalation logic
    typedef struct packed {
        logic load;
        logic tick;
        logic expire;
    } wd_evt_t;

    // Escalation flag state
    typedef struct packed {
        logic irq_flag;
        logic rst_flag;
    } wd_flags_t;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic       tick_d;

    always_comb begin
        s_d    = s_q;
        // ">=" keeps the divider safe when the prescale value shrinks mid-period
        tick_d = run_i && !load_i && (s_q.phase >= prescale_i);
        if (load_i) begin
            s_d.phase = '0;
        end else if (run_i) begin
            if (tick_d) begin
                s_d.phase = '0;
            end else begin
                s_d.phase = s_q.phase + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = tick_d;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic             tick_i,
    output logic             load_o,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] timeout_seen;
        logic             enable_seen;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] reload_val;
    logic             load_d;
    logic             expire_d;

    always_comb begin
        s_d        = s_q;
        reload_val = (timeout_i == '0) ? ONE : timeout_i;
        load_d     = (enable_i && !s_q.enable_seen) || (timeout_i != s_q.timeout_seen);
        expire_d   = tick_i && !load_d && (s_q.count <= ONE);

        if (load_d) begin
            s_d.count = reload_val;
        end else if (expire_d) begin
            s_d.count = reload_val;
        end else if (tick_i) begin
            s_d.count = s_q.count - ONE;
        end

        s_d.timeout_seen = timeout_i;
        s_d.enable_seen  = enable_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o   = load_d;
    assign expire_o = expire_d;
    assign count_o  = s_q.count;

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    input  logic irq_en_i,
    input  logic rst_en_i,
    output logic irq_o,
    output logic sys_rst_o,
    output logic irq_flag_o,
    output logic rst_flag_o
);

    wd_flags_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // A second expiry with no acknowledge in between escalates; the reset flag is sticky
        if (expire_i && s_q.irq_flag && !clear_i) begin
            s_d.rst_flag = 1'b1;
        end
        if (expire_i) begin
            s_d.irq_flag = 1'b1;
        end else if (clear_i) begin
            s_d.irq_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o      = s_q.irq_flag && irq_en_i;
    assign sys_rst_o  = s_q.rst_flag && rst_en_i;
    assign irq_flag_o = s_q.irq_flag;
    assign rst_flag_o = s_q.rst_flag;

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic             cfg_enable,
    input  logic             cfg_irq_en,
    input  logic             cfg_rst_en,
    input  logic             irq_clear,
    input  logic             suspend,
    output logic             irq,
    output logic             sys_rst,
    output logic [CNT_W-1:0] count
);

    wd_evt_t evt_w;
    logic    run_w;
    logic    load_w;
    logic    tick_w;
    logic    expire_w;
    logic    irq_flag_w;
    logic    rst_flag_w;

    assign run_w = cfg_enable && !suspend;

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .load_i     (load_w),
        .prescale_i (cfg_prescale),
        .tick_o     (tick_w)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (cfg_enable),
        .timeout_i (cfg_timeout),
        .tick_i    (tick_w),
        .load_o    (load_w),
        .expire_o  (expire_w),
        .count_o   (count)
    );

    assign evt_w = '{load: load_w, tick: tick_w, expire: expire_w};

    wdog_escalate u_esc (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (evt_w.expire),
        .clear_i    (irq_clear),
        .irq_en_i   (cfg_irq_en),
        .rst_en_i   (cfg_rst_en),
        .irq_o      (irq),
        .sys_rst_o  (sys_rst),
        .irq_flag_o (irq_flag_w),
        .rst_flag_o (rst_flag_w)
    );

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_timeout,
    input logic             cfg_enable,
    input logic             cfg_irq_en,
    input logic             cfg_rst_en,
    input logic             irq_clear,
    input logic             suspend,
    input logic             irq,
    input logic             sys_rst,
    input logic [CNT_W-1:0] count,
    input logic             load_w,
    input logic             tick_w,
    input logic             expire_w,
    input logic             irq_flag_w,
    input logic             rst_flag_w
);

    assert_reload_on_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w |=> count == (($past(cfg_timeout) == '0) ? CNT_W'(1) : $past(cfg_timeout)));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> count == (($past(cfg_timeout) == '0) ? CNT_W'(1) : $past(cfg_timeout)));

    assert_escalate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_w && irq_flag_w && !irq_clear) |=> rst_flag_w);

    assert_clear_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !tick_w && !load_w) |=> $stable(count));

    assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !load_w) |=> $stable(count));

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !load_w) |=> $stable(count));

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w |=> (irq == cfg_irq_en));

    assert_rst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag_w |=> rst_flag_w);

    assert_sysrst_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && cfg_rst_en) |=> (sys_rst || !cfg_rst_en));

    assert_no_zero_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !suspend && tick_w) |=> (count != '0));

endmodule

bind wdog_core wdog_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_timeout (cfg_timeout),
    .cfg_enable  (cfg_enable),
    .cfg_irq_en  (cfg_irq_en),
    .cfg_rst_en  (cfg_rst_en),
    .irq_clear   (irq_clear),
    .suspend     (suspend),
    .irq         (irq),
    .sys_rst     (sys_rst),
    .count       (count),
    .load_w      (load_w),
    .tick_w      (tick_w),
    .expire_w    (expire_w),
    .irq_flag_w  (irq_flag_w),
    .rst_flag_w  (rst_flag_w)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;

    localparam int CW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_timeout = '0;
    logic [PW-1:0] cfg_prescale = '0;
    logic          cfg_enable = 1'b0;
    logic          cfg_irq_en = 1'b0;
    logic          cfg_rst_en = 1'b0;
    logic          irq_clear = 1'b0;
    logic          suspend = 1'b0;
    logic          irq;
    logic          sys_rst;
    logic [CW-1:0] count;

    always #2 clk = ~clk;

    wdog_core #(.CNT_W(CW), .PRE_W(PW)) u_wdog_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_timeout  (cfg_timeout),
        .cfg_prescale (cfg_prescale),
        .cfg_enable   (cfg_enable),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_rst_en   (cfg_rst_en),
        .irq_clear    (irq_clear),
        .suspend      (suspend),
        .irq          (irq),
        .sys_rst      (sys_rst),
        .count        (count)
    );

    // Behavioural reference state
    int    m_cnt, m_phase, m_prev_to;
    bit    m_irqf, m_rstf, m_prev_en;
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0; m_prev_to = 0;
            m_irqf = 0; m_rstf = 0; m_prev_en = 0;
        end else begin
            int  eff;
            bit  fired, expired;
            fired   = 0;
            expired = 0;
            eff = (cfg_timeout == 0) ? 1 : int'(cfg_timeout);
            if ((cfg_enable && !m_prev_en) || (int'(cfg_timeout) != m_prev_to)) begin
                m_cnt = eff;
                m_phase = 0;
            end else if (cfg_enable && !suspend) begin
                if (m_phase >= int'(cfg_prescale)) begin
                    fired = 1; m_phase = 0;
                end else begin
                    m_phase++;
                end
                if (fired) begin
                    if (m_cnt <= 1) begin
                        expired = 1; m_cnt = eff;
                    end else begin
                        m_cnt--;
                    end
                end
            end
            if (expired && m_irqf && !irq_clear) m_rstf = 1;
            if (expired) m_irqf = 1;
            else if (irq_clear) m_irqf = 0;
            m_prev_en = cfg_enable;
            m_prev_to = int'(cfg_timeout);
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: wait to the falling edge, compare all outputs with the model
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cur_req, int'(count), m_cnt, "count");
            check(cur_req, int'(irq), int'(m_irqf && cfg_irq_en), "irq");
            check(cur_req, int'(sys_rst), int'(m_rstf && cfg_rst_en), "sys_rst");
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic core_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        check("R1", int'(count), 0, "count after reset");
        check("R1", int'(irq), 0, "irq after reset");
        check("R1", int'(sys_rst), 0, "sys_rst after reset");

        // R4/R5: run unattended, expire, then escalate
        cur_req = "R4";
        cfg_timeout = 8'd5; cfg_irq_en = 1; cfg_rst_en = 1; cfg_enable = 1;
        step(1);
        check("R2", int'(count), 5, "count after enable load");
        step(6);
        cur_req = "R5";
        step(8);
        check("R5", int'(sys_rst), 1, "escalated reset");

        // R10: the sticky flag survives clear, disable and reload
        cur_req = "R10";
        irq_clear = 1; step(3); irq_clear = 0;
        cfg_enable = 0; step(4);
        cfg_timeout = 8'd9; cfg_enable = 1; step(5);
        check("R10", int'(sys_rst), 1, "sticky reset");
        core_reset();
        check("R10", int'(sys_rst), 0, "cleared by rst_n");

        // R3 and R6: prescaler with periodic acknowledge; also max prescale
        cur_req = "R3";
        cfg_timeout = 8'd4; cfg_prescale = 4'd3; cfg_enable = 1;
        step(40);
        for (int k = 0; k < 6; k++) begin
            cur_req = "R6";
            irq_clear = 1; step(1); irq_clear = 0;
            step(7 + k);
        end
        cur_req = "R3";
        cfg_prescale = 4'd15; cfg_timeout = 8'd3;
        step(120);

        // R6: clear swept across every offset around an expiry
        for (int off = 0; off < 8; off++) begin
            core_reset();
            cur_req = "R6";
            cfg_prescale = 4'd0; cfg_timeout = 8'd6; cfg_enable = 1;
            step(7);
            step(off);
            irq_clear = 1; step(1); irq_clear = 0;
            step(10);
        end
        core_reset();
        irq_clear = 1; cfg_timeout = 8'd2;
        step(30);
        check("R6", int'(sys_rst), 0, "held clear never escalates");
        irq_clear = 0;

        // R7: suspend freezes count and prescaler phase
        core_reset();
        cur_req = "R7";
        cfg_prescale = 4'd4; cfg_timeout = 8'd20; cfg_enable = 1;
        step(13);
        suspend = 1; step(9);
        suspend = 0; step(12);
        suspend = 1; step(1); suspend = 0; step(15);

        // R8 and R2: disable holds, re-enable and timeout change reload
        cur_req = "R8";
        cfg_enable = 0; step(10);
        cfg_enable = 1; step(1);
        check("R8", int'(count), 20, "reload on re-enable");
        step(7);
        cur_req = "R2";
        cfg_timeout = 8'd11; step(1);
        check("R2", int'(count), 11, "reload on new timeout");
        step(20);

        // R9: output enables gate only the pins
        core_reset();
        cur_req = "R9";
        cfg_prescale = 4'd0; cfg_timeout = 8'd3;
        cfg_irq_en = 0; cfg_rst_en = 0; cfg_enable = 1;
        step(10);
        cfg_irq_en = 1; step(1);
        check("R9", int'(irq), 1, "irq visible once enabled");
        cfg_rst_en = 1; step(1);
        check("R9", int'(sys_rst), 1, "reset visible once enabled");

        // R11: timeout of zero
        core_reset();
        cur_req = "R11";
        cfg_timeout = 8'd0; cfg_prescale = 4'd2; cfg_enable = 1;
        step(15);
        check("R11", int'(count), 1, "zero timeout count");

        // R4: full-range timeout with maximum prescale
        core_reset();
        cur_req = "R4";
        cfg_timeout = 8'd255; cfg_prescale = 4'd15; cfg_enable = 1;
        irq_clear = 1;
        step(4200);
        irq_clear = 0;
        step(20);

        report();
    end

endmodule